// File: doc/BRIEF.md
# Dual-Read Register File with Pointer Pairs

This block is the working register store of a small 8-bit processor core. It holds 32 byte-wide registers. Two read ports deliver operands to the arithmetic unit in the same cycle, and a single write port takes the result back at the next clock edge, so a register-to-register operation completes in one cycle. Reads are combinational. Writes happen on the rising clock edge.

The six highest registers are also visible as three 16-bit address words: X, Y and Z. Each word has its own output, and a separate 16-bit write port loads both bytes of one word at once. The Z word has its own output, so the program-memory lookup path can use it directly. The block also acts as the lowest 32 bytes of the data address space. A load or store whose address falls in 0x00 to 0x1F reads or writes the matching register. Any higher address is left to other memories.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-low reset clears all 32 registers to 0x00, so all three pointer outputs read 0x0000.
- R2: `rd_a_data` and `rd_b_data` show, without a clock, the registers chosen by `rd_a_idx` and `rd_b_idx`. The two indices are independent, so two different registers can be read at once.
- R3: When `alu_we` is high, register `alu_widx` takes `alu_wdata` at the rising edge. A read of that register in the same cycle returns the old value, and the new value is visible from the next cycle.
- R4: `ptr_x` is {r27, r26}, `ptr_y` is {r29, r28} and `ptr_z` is {r31, r30}. In each pair the lower-numbered register is the low byte.
- R5: When `ptr_we` is high, `ptr_sel` chooses the pair to load (0 = X, 1 = Y, 2 = Z). Both bytes take `ptr_wdata` at the same edge. `ptr_sel` = 3 writes nothing.
- R6: A pointer write beats any 8-bit write (arithmetic or data-space) aimed at either register of the chosen pair in the same cycle.
- R7: When an arithmetic write and a data-space write hit the same register in one cycle, the arithmetic write is the one stored.
- R8: When `ds_re` is high and `ds_addr` is below 0x20, `ds_hit` is 1 and `ds_rdata` shows register `ds_addr`.
- R9: When `ds_we` is high and `ds_addr` is below 0x20, register `ds_addr` takes `ds_wdata` at the rising edge.
- R10: A data-space address of 0x20 or above touches no register: a write is dropped even if its low five bits match a register, `ds_hit` stays 0, and `ds_rdata` reads 0x00.
- R11: An arithmetic write and a data-space write aimed at different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | First operand register index |
| rd_a_data | output | 8 | First operand value |
| rd_b_idx | input | 5 | Second operand register index |
| rd_b_data | output | 8 | Second operand value |
| alu_we | input | 1 | Result write enable |
| alu_widx | input | 5 | Result destination register |
| alu_wdata | input | 8 | Result value |
| ds_re | input | 1 | Data-space read strobe |
| ds_we | input | 1 | Data-space write strobe |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space store value |
| ds_rdata | output | 8 | Data-space load value (0 when not hit) |
| ds_hit | output | 1 | Read address lies in the register window |
| ptr_we | input | 1 | Pointer word write enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Pointer word value |
| ptr_x | output | 16 | X word {r27, r26} |
| ptr_y | output | 16 | Y word {r29, r28} |
| ptr_z | output | 16 | Z word {r31, r30} |

## Verification
The stimulus table writes through each of the three write paths alone, then drives pairs of them together. One pair aims at the same register and shows which path wins. Another aims at different registers and shows that neither write hides the other. Out-of-window stores use addresses whose low five bits alias a live register, so a block that truncates the address is caught. Pointer writes are checked both byte by byte and through the word outputs, which catches swapped byte order. Directed tests compare the operand value before and after a write edge and read two registers at once to show the two ports are independent.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared types of the register file: the pointer select code.
// Assumes the three pointer pairs sit at the top of the file in X, Y, Z order.
package rf_pkg;
    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    localparam int PTR_PAIRS = 3;
endpackage

// File: rtl/rf_write_arbiter.sv
// Module rf_write_arbiter
// For each register, decides whether it is written this cycle and with which byte.
// Priority from highest: pointer word, arithmetic result, data-space store.
// Assumes NUM_REGS is even and that the pointer pairs fill its top six entries.
module rf_write_arbiter
    import rf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    parameter int DS_AW    = 16
) (
    input  logic                       alu_we,
    input  logic [$clog2(NUM_REGS)-1:0] alu_idx,
    input  logic [DATA_W-1:0]          alu_wdata,
    input  logic                       ds_we,
    input  logic [DS_AW-1:0]           ds_addr,
    input  logic [DATA_W-1:0]          ds_wdata,
    input  logic                       ptr_we,
    input  ptr_sel_e                   ptr_sel,
    input  logic [2*DATA_W-1:0]        ptr_wdata,
    output logic [NUM_REGS-1:0]        wen,
    output logic [NUM_REGS*DATA_W-1:0] wdat
);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int PTR_BASE = NUM_REGS - 2 * PTR_PAIRS;

    logic             ds_in_win;
    logic [IDX_W-1:0] ds_idx;

    // Data-space window decode: only the lowest NUM_REGS addresses map here
    always_comb begin
        ds_in_win = (ds_addr < DS_AW'(NUM_REGS));
        ds_idx    = ds_addr[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic              ptr_hit;
        logic [DATA_W-1:0] ptr_byte;
        logic              alu_hit;
        logic              ds_hit;

        if (i >= PTR_BASE) begin : g_ptr
            localparam int PAIR = (i - PTR_BASE) / 2;
            localparam int HALF = (i - PTR_BASE) % 2;
            assign ptr_hit  = ptr_we && (ptr_sel == ptr_sel_e'(PAIR));
            assign ptr_byte = ptr_wdata[HALF*DATA_W +: DATA_W];
        end else begin : g_plain
            assign ptr_hit  = 1'b0;
            assign ptr_byte = '0;
        end

        assign alu_hit = alu_we && (alu_idx == IDX_W'(i));
        assign ds_hit  = ds_we && ds_in_win && (ds_idx == IDX_W'(i));

        // Per-register source selection in fixed priority order
        always_comb begin
            wen[i] = ptr_hit || alu_hit || ds_hit;
            if (ptr_hit)      wdat[i*DATA_W +: DATA_W] = ptr_byte;
            else if (alu_hit) wdat[i*DATA_W +: DATA_W] = alu_wdata;
            else              wdat[i*DATA_W +: DATA_W] = ds_wdata;
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module rf_storage
// The register array itself: one byte-wide flop bank per register with its own enable.
// Assumes a synchronous active-low reset that clears every register.
module rf_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        wen,
    input  logic [NUM_REGS*DATA_W-1:0] wdat,
    output logic [NUM_REGS*DATA_W-1:0] q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
        // Holds register i; loads on its enable, clears on reset
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i*DATA_W +: DATA_W] <= '0;
            else if (wen[i]) q[i*DATA_W +: DATA_W] <= wdat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/rf_read_ports.sv
// Module rf_read_ports
// Combinational reads: two operand ports, the data-space load port and the three pointer words.
// Assumes q is the current register contents, so same-cycle reads see the pre-write value.
module rf_read_ports
    import rf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    parameter int DS_AW    = 16
) (
    input  logic [NUM_REGS*DATA_W-1:0]  q,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
    input  logic                        ds_re,
    input  logic [DS_AW-1:0]            ds_addr,
    output logic [DATA_W-1:0]           rd_a_data,
    output logic [DATA_W-1:0]           rd_b_data,
    output logic [DATA_W-1:0]           ds_rdata,
    output logic                        ds_hit,
    output logic [2*DATA_W-1:0]         ptr_x,
    output logic [2*DATA_W-1:0]         ptr_y,
    output logic [2*DATA_W-1:0]         ptr_z
);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int PTR_BASE = NUM_REGS - 2 * PTR_PAIRS;

    logic [DATA_W-1:0]         regs [NUM_REGS];
    logic [2*DATA_W-1:0]       words [PTR_PAIRS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
        assign regs[i] = q[i*DATA_W +: DATA_W];
    end

    for (genvar p = 0; p < PTR_PAIRS; p++) begin : g_word
        assign words[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
    end

    // Two independent operand multiplexers
    always_comb begin
        rd_a_data = regs[rd_a_idx];
        rd_b_data = regs[rd_b_idx];
    end

    // Data-space load: hit only inside the register window, zero otherwise
    always_comb begin
        ds_hit   = ds_re && (ds_addr < DS_AW'(NUM_REGS));
        ds_rdata = ds_hit ? regs[ds_addr[IDX_W-1:0]] : '0;
    end

    // Pointer words, low byte in the lower-numbered register
    always_comb begin
        ptr_x = words[0];
        ptr_y = words[1];
        ptr_z = words[2];
    end
endmodule

// File: rtl/gpr_file.sv
// Module gpr_file
// Top of the register file: operand reads, result write, data-space window and pointer words.
// Assumes the controller normally does not issue an arithmetic and a data-space write together;
// if it does, per-register priority applies (pointer, then arithmetic, then data space).
module gpr_file #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 8,
    parameter int DS_AW    = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int PTR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              alu_we,
    input  logic [IDX_W-1:0]  alu_widx,
    input  logic [DATA_W-1:0] alu_wdata,
    input  logic              ds_re,
    input  logic              ds_we,
    input  logic [DS_AW-1:0]  ds_addr,
    input  logic [DATA_W-1:0] ds_wdata,
    output logic [DATA_W-1:0] ds_rdata,
    output logic              ds_hit,
    input  logic              ptr_we,
    input  logic [1:0]        ptr_sel,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  ptr_x,
    output logic [PTR_W-1:0]  ptr_y,
    output logic [PTR_W-1:0]  ptr_z
);
    import rf_pkg::*;

    localparam int PTR_BASE = NUM_REGS - 2 * PTR_PAIRS;

    logic [NUM_REGS-1:0]        wen;
    logic [NUM_REGS*DATA_W-1:0] wdat;
    logic [NUM_REGS*DATA_W-1:0] q;
    ptr_sel_e                   sel_e;

    assign sel_e = ptr_sel_e'(ptr_sel);

    rf_write_arbiter #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DS_AW(DS_AW)) u_arb (
        .alu_we   (alu_we),
        .alu_idx  (alu_widx),
        .alu_wdata(alu_wdata),
        .ds_we    (ds_we),
        .ds_addr  (ds_addr),
        .ds_wdata (ds_wdata),
        .ptr_we   (ptr_we),
        .ptr_sel  (sel_e),
        .ptr_wdata(ptr_wdata),
        .wen      (wen),
        .wdat     (wdat)
    );

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wen  (wen),
        .wdat (wdat),
        .q    (q)
    );

    rf_read_ports #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DS_AW(DS_AW)) u_rd (
        .q        (q),
        .rd_a_idx (rd_a_idx),
        .rd_b_idx (rd_b_idx),
        .ds_re    (ds_re),
        .ds_addr  (ds_addr),
        .rd_a_data(rd_a_data),
        .rd_b_data(rd_b_data),
        .ds_rdata (ds_rdata),
        .ds_hit   (ds_hit),
        .ptr_x    (ptr_x),
        .ptr_y    (ptr_y),
        .ptr_z    (ptr_z)
    );

    // True when a live pointer write covers register idx this cycle
    function automatic logic ptr_covers(input logic [IDX_W-1:0] idx);
        int pair_lo;
        pair_lo = PTR_BASE + 2 * int'(ptr_sel);
        return ptr_we && (ptr_sel != 2'd3) &&
               ((int'(idx) == pair_lo) || (int'(idx) == pair_lo + 1));
    endfunction

    // R3 and R7: an uncontested result write is what the register holds next cycle
    p_alu_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !ptr_covers(alu_widx)) |=>
        (q[$past(alu_widx)*DATA_W +: DATA_W] == $past(alu_wdata)));

    // R5: a Z word write shows up whole on the Z output next cycle
    p_ptr_z_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel == 2'd2) |=> (ptr_z == $past(ptr_wdata)));

    // R6: a X word write wins over any byte write in the same cycle
    p_ptr_x_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel == 2'd0) |=> (ptr_x == $past(ptr_wdata)));

    // R8: a window load returns the stored byte and raises the hit flag
    p_ds_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_re && ds_addr < DS_AW'(NUM_REGS)) |->
        (ds_hit && ds_rdata == q[ds_addr[IDX_W-1:0]*DATA_W +: DATA_W]));

    // R10: an out-of-window store with no other writer leaves every register unchanged
    p_ds_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_addr >= DS_AW'(NUM_REGS) && !alu_we && !ptr_we) |=> $stable(q));

    // R10: loads outside the window never report a hit
    p_ds_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_addr >= DS_AW'(NUM_REGS)) |-> (!ds_hit && ds_rdata == '0));

    // R5: with no writer active the file holds its contents
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_we && !ds_we && (!ptr_we || ptr_sel == 2'd3)) |=> $stable(q));
endmodule

// File: tb/gpr_file_bench.sv
`timescale 1ns/1ps
module gpr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, alu_widx = '0;
    logic [7:0]  rd_a_data, rd_b_data, alu_wdata = '0, ds_wdata = '0, ds_rdata;
    logic        alu_we = 1'b0, ds_re = 1'b0, ds_we = 1'b0, ds_hit, ptr_we = 1'b0;
    logic [15:0] ds_addr = '0, ptr_wdata = '0, ptr_x, ptr_y, ptr_z;
    logic [1:0]  ptr_sel = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
        .ds_re(ds_re), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_hit(ds_hit),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    typedef struct packed {
        logic        a_we;
        logic [4:0]  a_idx;
        logic [7:0]  a_d;
        logic        d_we;
        logic [15:0] d_a;
        logic [7:0]  d_d;
        logic        p_we;
        logic [1:0]  p_sel;
        logic [15:0] p_d;
        logic [4:0]  chk;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  8'h3C, 1'b0, 16'h0000, 8'h00, 1'b0, 2'd0, 16'h0000, 5'd5,  8'h3C, 8'd3},  // R3
        '{1'b0, 5'd0,  8'h00, 1'b1, 16'h0006, 8'hA5, 1'b0, 2'd0, 16'h0000, 5'd6,  8'hA5, 8'd9},  // R9
        '{1'b0, 5'd0,  8'h00, 1'b0, 16'h0000, 8'h00, 1'b1, 2'd0, 16'h1234, 5'd26, 8'h34, 8'd5},  // R5
        '{1'b1, 5'd28, 8'h11, 1'b0, 16'h0000, 8'h00, 1'b1, 2'd1, 16'hBEEF, 5'd28, 8'hEF, 8'd6},  // R6
        '{1'b1, 5'd10, 8'h77, 1'b1, 16'h000A, 8'h88, 1'b0, 2'd0, 16'h0000, 5'd10, 8'h77, 8'd7},  // R7
        '{1'b1, 5'd11, 8'h22, 1'b1, 16'h000C, 8'h33, 1'b0, 2'd0, 16'h0000, 5'd12, 8'h33, 8'd11}, // R11
        '{1'b0, 5'd0,  8'h00, 1'b1, 16'h0025, 8'h99, 1'b0, 2'd0, 16'h0000, 5'd5,  8'h3C, 8'd10}, // R10
        '{1'b0, 5'd0,  8'h00, 1'b0, 16'h0000, 8'h00, 1'b1, 2'd3, 16'hDEAD, 5'd30, 8'h00, 8'd5},  // R5
        '{1'b0, 5'd0,  8'h00, 1'b1, 16'h001F, 8'h5A, 1'b0, 2'd0, 16'h0000, 5'd31, 8'h5A, 8'd9},  // R9
        '{1'b0, 5'd0,  8'h00, 1'b1, 16'h001E, 8'h01, 1'b1, 2'd2, 16'hC0DE, 5'd30, 8'hDE, 8'd6},  // R6
        '{1'b1, 5'd0,  8'h01, 1'b0, 16'h0000, 8'h00, 1'b0, 2'd0, 16'h0000, 5'd0,  8'h01, 8'd3},  // R3
        '{1'b0, 5'd0,  8'h00, 1'b1, 16'h0120, 8'h44, 1'b0, 2'd0, 16'h0000, 5'd0,  8'h01, 8'd10}  // R10
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: every register reads zero after reset
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            #0.1;
            if (rd_a_data !== 8'h00) bad++;
        end
        check(32'(bad), 32'd0, "R1 regs nonzero after reset");
        check({16'h0, ptr_z}, 32'h0, "R1 ptr_z after reset");

        // Table walk: apply one cycle of writes, then read back through port B
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            alu_we = VECS[v].a_we; alu_widx = VECS[v].a_idx; alu_wdata = VECS[v].a_d;
            ds_we = VECS[v].d_we;  ds_addr = VECS[v].d_a;    ds_wdata = VECS[v].d_d;
            ptr_we = VECS[v].p_we; ptr_sel = VECS[v].p_sel;  ptr_wdata = VECS[v].p_d;
            @(negedge clk);
            alu_we = 1'b0; ds_we = 1'b0; ptr_we = 1'b0; ds_addr = '0;
            rd_b_idx = VECS[v].chk;
            #1;
            check({24'h0, rd_b_data}, {24'h0, VECS[v].exp},
                  $sformatf("R%0d vector %0d", VECS[v].req, v));
        end

        // R4: pointer words assembled low byte from the lower register
        check({16'h0, ptr_x}, 32'h1234, "R4 ptr_x");
        check({16'h0, ptr_y}, 32'hBEEF, "R4 ptr_y");
        check({16'h0, ptr_z}, 32'hC0DE, "R4 ptr_z");

        // R2: two different registers read together
        rd_a_idx = 5'd26; rd_b_idx = 5'd27;
        #1;
        check({24'h0, rd_a_data}, 32'h34, "R2 port A r26");
        check({24'h0, rd_b_data}, 32'h12, "R2 port B r27");

        // R3: same-cycle read returns the old value, new value after the edge
        @(negedge clk);
        alu_we = 1'b1; alu_widx = 5'd5; alu_wdata = 8'h66; rd_a_idx = 5'd5;
        #1;
        check({24'h0, rd_a_data}, 32'h3C, "R3 old value before edge");
        @(negedge clk);
        alu_we = 1'b0;
        #1;
        check({24'h0, rd_a_data}, 32'h66, "R3 new value after edge");

        // R8: load inside the window
        ds_re = 1'b1; ds_addr = 16'h001C;
        #1;
        check({31'h0, ds_hit}, 32'h1, "R8 hit flag");
        check({24'h0, ds_rdata}, 32'hEF, "R8 load value r28");

        // R10: load outside the window, low bits alias r28
        ds_addr = 16'h003C;
        #1;
        check({31'h0, ds_hit}, 32'h0, "R10 no hit outside window");
        check({24'h0, ds_rdata}, 32'h00, "R10 zero data outside window");
        ds_re = 1'b0; ds_addr = '0;

        // R1: reset applied mid-run clears the file
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_a_idx = 5'd5;
        #1;
        check({16'h0, ptr_z}, 32'h0, "R1 ptr_z after second reset");
        check({24'h0, rd_a_data}, 32'h0, "R1 r5 after second reset");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule